// File: doc/BRIEF.md
# Phase-Frequency Detector with Antibacklash Pulse

This block is a synchronous model of a tri-state phase-frequency detector. A fast sampling clock oversamples two edge signals: the divided reference and the divided feedback. A rising edge on the reference sets an `up` state flop, and a rising edge on the feedback sets a `dn` state flop. Each flop's output drives a charge-pump control line.

When both flops are set, a clear is not applied at once. It passes through a delay of `ABL_CYCLES` sampling cycles and then clears both flops on the same edge. As a result, every comparison produces a pulse of at least the antibacklash width on both outputs, even at zero phase error. This removes the deadzone of the transfer function. The charge pump, the loop filter and the dividers lie outside this block.

Each input passes through a `SYNC_STAGES`-deep sampling chain. An edge is a low-to-high step between the last two stages of that chain.

Top module: `pfd_abl`

## Requirements
- R1: While `rst_ni` is low, `up_o` and `dn_o` are 0 and the clear-delay counter is held at zero. After release, both outputs remain 0 until an input rises.
- R2: A low-to-high step on `ref_i` makes `up_o` high exactly `SYNC_STAGES`+1 clock edges after the step, provided the step is stable before the first of those edges.
- R3: A low-to-high step on `fb_i` makes `dn_o` high exactly `SYNC_STAGES`+1 clock edges after the step.
- R4: Once `up_o` and `dn_o` are both high, both stay high for exactly `ABL_CYCLES` sampled cycles. Both then fall on the same clock edge.
- R5: When one input leads the other by L cycles, the leading output is high for L+`ABL_CYCLES` cycles and the lagging output is high for `ABL_CYCLES` cycles. Each output rises once per comparison.
- R6: When both inputs rise in the same sampling cycle, both outputs rise together and are each high for exactly `ABL_CYCLES` cycles.
- R7: A rising edge that arrives while its own output is already high has no effect: it adds no width and no second pulse. A level held high does not retrigger.
- R8: An output that is high while the other is low stays high until the other output has also been set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Divided reference edge signal |
| fb_i | input | 1 | Divided feedback edge signal |
| up_o | output | 1 | Charge-pump source control |
| dn_o | output | 1 | Charge-pump sink control |

## Verification
The bound checker covers the following on every cycle:
- a detected edge sets its flop;
- a lone set flop holds;
- the overlap of `up_o` and `dn_o` lasts exactly the antibacklash count;
- both outputs fall together;
- neither output is ever shorter than that count.

Some properties only the bench scenarios can show, because they depend on what happened at the input pins:
- the end-to-end latency from the pins;
- the pulse widths over a sweep of lead and lag offsets;
- the loss of a repeated edge;
- the clearing effect of reset in the middle of a pulse.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // {dn, up} occupancy of the two state flops
  typedef enum logic [1:0] {
    PFD_IDLE = 2'b00,
    PFD_UP   = 2'b01,
    PFD_DN   = 2'b10,
    PFD_BOTH = 2'b11
  } pfd_state_e;

  localparam int unsigned PFD_CH_REF = 0;
  localparam int unsigned PFD_CH_FB  = 1;
  localparam int unsigned PFD_NUM_CH = 2;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  // sampling chain plus one history stage
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], sig_i};
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/pfd_state_ff.sv
module pfd_state_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;   // clear wins over a late edge
    else if (set_i)  q_o <= 1'b1;
  end
endmodule

// File: rtl/pfd_abl_delay.sv
module pfd_abl_delay #(
  parameter int unsigned ABL_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic clr_o
);
  localparam int unsigned CNT_W = (ABL_CYCLES > 1) ? $clog2(ABL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ABL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign clr_o = arm_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!arm_i || clr_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pfd_abl.sv
module pfd_abl
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ABL_CYCLES  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  output logic up_o,
  output logic dn_o
);
  logic [PFD_NUM_CH-1:0] in_vec;
  logic [PFD_NUM_CH-1:0] rise;
  logic [PFD_NUM_CH-1:0] state_q;
  logic                  clr;
  pfd_state_e            state;

  assign in_vec[PFD_CH_REF] = ref_i;
  assign in_vec[PFD_CH_FB]  = fb_i;

  for (genvar ch = 0; ch < PFD_NUM_CH; ch++) begin : g_ch
    pfd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (in_vec[ch]),
      .rise_o(rise[ch])
    );
    pfd_state_ff u_ff (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (rise[ch]),
      .clr_i (clr),
      .q_o   (state_q[ch])
    );
  end

  assign state = pfd_state_e'(state_q);

  pfd_abl_delay #(.ABL_CYCLES(ABL_CYCLES)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (state == PFD_BOTH),
    .clr_o (clr)
  );

  assign up_o = state_q[PFD_CH_REF];
  assign dn_o = state_q[PFD_CH_FB];
endmodule

// File: rtl/pfd_abl_chk.sv
module pfd_abl_chk #(
  parameter int unsigned ABL_CYCLES = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_rise_i,
  input logic fb_rise_i,
  input logic up_i,
  input logic dn_i
);
  logic [15:0] up_len_q, dn_len_q, both_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_len_q   <= '0;
      dn_len_q   <= '0;
      both_len_q <= '0;
    end else begin
      up_len_q   <= up_i ? ((&up_len_q) ? up_len_q : up_len_q + 1'b1) : '0;
      dn_len_q   <= dn_i ? ((&dn_len_q) ? dn_len_q : dn_len_q + 1'b1) : '0;
      both_len_q <= (up_i && dn_i) ? ((&both_len_q) ? both_len_q : both_len_q + 1'b1) : '0;
    end
  end

  a_r2_ref_sets_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_rise_i && !(up_i && dn_i) |=> up_i);

  a_r3_fb_sets_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rise_i && !(up_i && dn_i) |=> dn_i);

  a_r4_fall_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(up_i) |-> $fell(dn_i));

  a_r4_overlap_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(up_i) |-> (both_len_q == 16'(ABL_CYCLES)));

  a_r6_up_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(up_i) |-> (up_len_q >= 16'(ABL_CYCLES)));

  a_r6_dn_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dn_i) |-> (dn_len_q >= 16'(ABL_CYCLES)));

  a_r8_up_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_i && !dn_i |=> up_i);

  a_r8_dn_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_i && !up_i |=> dn_i);
endmodule

bind pfd_abl pfd_abl_chk #(.ABL_CYCLES(ABL_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ref_rise_i(rise[0]),
  .fb_rise_i (rise[1]),
  .up_i      (up_o),
  .dn_i      (dn_o)
);

// File: tb/tb_pfd_abl.sv
`timescale 1ns/1ps
module tb_pfd_abl;
  localparam int SYNC = 2;
  localparam int ABL  = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_i = 1'b0;
  logic fb_i = 1'b0;
  logic up_o, dn_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  int up_w, dn_w, up_r, dn_r, first_up, first_dn;
  logic up_d = 1'b0, dn_d = 1'b0;

  pfd_abl #(.SYNC_STAGES(SYNC), .ABL_CYCLES(ABL)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i),
    .up_o(up_o), .dn_o(dn_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (up_o) up_w++;
    if (dn_o) dn_w++;
    if (up_o && !up_d) up_r++;
    if (dn_o && !dn_d) dn_r++;
    if (up_o && first_up < 0) first_up = cyc;
    if (dn_o && first_dn < 0) first_dn = cyc;
    up_d = up_o;
    dn_d = dn_o;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    up_w = 0; dn_w = 0; up_r = 0; dn_r = 0;
    first_up = -1; first_dn = -1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // ref pulses at ra (and ra2 if >=0), fb pulse at fa; each input high 2 cycles
  task automatic run(input int ra, input int ra2, input int fa,
                     output int ref_cyc, output int fb_cyc);
    ref_cyc = 0; fb_cyc = 0;
    clear_mon();
    for (int k = 0; k < 40; k++) begin
      step();
      if (k == ra) ref_cyc = cyc;
      if (k == fa) fb_cyc = cyc;
      ref_i = ((k >= ra) && (k < ra + 2)) || ((ra2 >= 0) && (k >= ra2) && (k < ra2 + 2));
      fb_i  = (k >= fa) && (k < fa + 2);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rc, fc, lead, exp_up, exp_dn;
    clear_mon();
    repeat (3) step();
    // R1: reset state
    check("R1 up_o in reset", int'(up_o), 0);
    check("R1 dn_o in reset", int'(dn_o), 0);
    rst_ni = 1'b1;
    clear_mon();
    repeat (10) step();
    check("R1 up_o idle after release", up_w, 0);
    check("R1 dn_o idle after release", dn_w, 0);

    // R2 R3 R4 R5 R6: sweep of lead/lag offsets
    for (int d = -6; d <= 6; d++) begin
      int ra, fa;
      ra = (d < 0) ? 5 - d : 5;
      fa = (d < 0) ? 5 : 5 + d;
      run(ra, -1, fa, rc, fc);
      lead = (d < 0) ? -d : d;
      exp_up = ((fa > ra) ? fa - ra : 0) + ABL;
      exp_dn = ((ra > fa) ? ra - fa : 0) + ABL;
      check("R2 up latency", first_up - rc, SYNC + 1);
      check("R3 dn latency", first_dn - fc, SYNC + 1);
      check(d == 0 ? "R6 up width same-cycle" : "R5 up width", up_w, exp_up);
      check(d == 0 ? "R6 dn width same-cycle" : "R5 dn width", dn_w, exp_dn);
      check("R5 up single pulse", up_r, 1);
      check("R5 dn single pulse", dn_r, 1);
      check("R4 overlap is lag+ABL minus lead", (up_w + dn_w - lead) / 2, ABL);
    end

    // R7 R8: second ref edge while up_o set is ignored
    run(2, 6, 12, rc, fc);
    check("R7 up width ignores repeat edge", up_w, 10 + ABL);
    check("R7 up single pulse", up_r, 1);
    check("R8 dn width", dn_w, ABL);

    // R7: held level does not retrigger
    clear_mon();
    step(); ref_i = 1'b1;
    repeat (6) step(); fb_i = 1'b1;
    repeat (20) step();
    check("R7 held ref single pulse", up_r, 1);
    check("R7 held ref width", up_w, 6 + ABL);
    ref_i = 1'b0; fb_i = 1'b0;
    repeat (5) step();

    // R1: reset mid-pulse clears at once
    clear_mon();
    ref_i = 1'b1;
    repeat (SYNC + 2) step();
    check("R8 up held before reset", int'(up_o), 1);
    ref_i = 1'b0;
    rst_ni = 1'b0;
    #0.5;
    check("R1 async clear of up_o", int'(up_o), 0);
    step();
    rst_ni = 1'b1;
    clear_mon();
    repeat (10) step();
    check("R1 no pulse after reset", up_w + dn_w, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule